// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and a 128K x 16 asynchronous static RAM. The host presents one request at a time: a read/write flag, a 17-bit word address, 16-bit write data and two byte enables. The controller accepts a request only when its ready output is high. It then drives the RAM's active-low select, write strobe, output enable and per-byte lane controls, and a tri-stated data bus. For read requests it returns the captured word with a one-cycle valid strobe.

Every analog limit is given in nanoseconds as a parameter, together with the clock period. The block rounds each limit up to whole clock cycles. A read holds the output enable low for the longest of the cycle-time and access-time budgets. A write places address, select, lanes and data first and then lowers the write strobe for the pulse budget. After a read, the block waits until the RAM has released the bus before its own drivers may switch on.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is held and while idle, select, write strobe, output enable and both lane controls are high (inactive), the data drivers are off and ready is high.
- R2: A request is taken on a clock edge where req_i and ready_o are both high. Ready stays low from the next cycle until recovery ends: RD_CYC+TURN_CYC cycles for a read, 1+PULSE_CYC+1 cycles for a write.
- R3: A read keeps select low, write high and output enable low for exactly RD_CYC cycles, where RD_CYC = max(ceil(tRC/T), ceil(tAA/T), ceil(tOE/T)) and T is the clock period.
- R4: Read data is sampled on the edge that ends the last output-enable cycle and is shown with rvalid_o high for exactly one cycle. Byte lanes that are not enabled return zero. be_i[0] selects bits 7:0 and lane control 0; be_i[1] selects bits 15:8 and lane control 1.
- R5: A write drives address, select, lanes and data with the write strobe high for one setup cycle. It then holds the strobe low for exactly PULSE_CYC = max(ceil(tWP/T), ceil(tWC/T)-1, ceil(tSelSU/T)-1, ceil(tDS/T)) cycles. Address and data stay stable throughout.
- R6: A write with a single byte enable changes only that byte of the addressed word.
- R7: The write strobe is low only while select is low and at least one lane control is low. Output enable and write strobe are never low together.
- R8: After a read, output enable stays high for TURN_CYC = ceil(tOHZ/T) cycles before ready returns. The data drivers switch on only after output enable has been high for at least TURN_CYC cycles.
- R9: A request with both byte enables clear completes the handshake but never lowers select. Memory is left unchanged, and a read of this kind returns zero.
- R10: The cycle in which the write strobe rises has select and both lane controls high. It is followed by one recovery cycle before ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables (bit 0 low byte) |
| ready_o | output | 1 | Controller idle, request accepted when high |
| rdata_o | output | 16 | Read data |
| rvalid_o | output | 1 | Read data valid, one cycle |
| ram_addr_o | output | 17 | RAM address |
| ram_cs_n_o | output | 1 | RAM select, active low |
| ram_we_n_o | output | 1 | RAM write strobe, active low |
| ram_oe_n_o | output | 1 | RAM output enable, active low |
| ram_lane_n_o | output | 2 | Byte lane controls, active low (bit 0 low byte) |
| ram_dq_io | inout | 16 | Tri-stated data bus |

## Verification
The bench builds the block with an 8 ns clock, so no nanosecond limit divides evenly. Each limit must therefore round up: reads last 7 cycles, write pulses 6 cycles and the turnaround 3 cycles. With these values, an off-by-one or round-down error in any budget changes a measured strobe width or ready latency. The timing limits keep their faster-grade default values. A behavioural RAM model on the shared bus lets partial-lane writes, masked reads and lane-less requests be observed through read-back.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_RECOVER
  } seq_state_e;

  function automatic int ns_to_cyc(int ns, int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cyc_fsm.sv
`timescale 1ns/1ps
module sram_cyc_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC    = 6,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 5,
  parameter int WREC_CYC  = 1,
  parameter int TURN_CYC  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  output logic       ready_o,
  output logic       accept_o,
  output logic       cap_o,
  output seq_state_e state_d_o
);

  localparam int MAX_C = imax(imax(RD_CYC, SETUP_CYC), imax(imax(PULSE_CYC, WREC_CYC), TURN_CYC));
  localparam int CNT_W = $clog2(MAX_C + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             rd_op_q, last;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o && req_i;

  always_comb begin
    unique case (state_q)
      ST_RD_WAIT:  lim = CNT_W'(RD_CYC - 1);
      ST_WR_SETUP: lim = CNT_W'(SETUP_CYC - 1);
      ST_WR_PULSE: lim = CNT_W'(PULSE_CYC - 1);
      ST_RECOVER:  lim = rd_op_q ? CNT_W'(TURN_CYC - 1) : CNT_W'(WREC_CYC - 1);
      default:     lim = '0;
    endcase
  end

  assign last = (cnt_q == lim);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    cap_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (req_i) state_d = we_i ? ST_WR_SETUP : ST_RD_WAIT;
      end
      ST_RD_WAIT: if (last) begin
        state_d = ST_RECOVER;
        cnt_d   = '0;
        cap_o   = 1'b1;
      end
      ST_WR_SETUP: if (last) begin
        state_d = ST_WR_PULSE;
        cnt_d   = '0;
      end
      ST_WR_PULSE: if (last) begin
        state_d = ST_RECOVER;
        cnt_d   = '0;
      end
      ST_RECOVER: if (last) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  assign state_d_o = state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rd_op_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (accept_o) rd_op_q <= !we_i;
    end
  end

  p_busy_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !ready_o);

  p_cap_ends_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> (state_q == ST_RECOVER) && rd_op_q);

endmodule

// File: rtl/sram_pin_drv.sv
`timescale 1ns/1ps
module sram_pin_drv
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 16,
  parameter int LANES     = DATA_W / 8,
  parameter int PULSE_CYC = 5,
  parameter int TURN_CYC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_state_e        state_d_i,
  input  logic              accept_i,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_cs_n_o,
  output logic              ram_we_n_o,
  output logic              ram_oe_n_o,
  output logic [LANES-1:0]  ram_lane_n_o,
  inout  wire  [DATA_W-1:0] ram_dq_io
);

  localparam int TC_W = $clog2(TURN_CYC + 1);
  localparam int WC_W = $clog2(PULSE_CYC + 2);

  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] wdata_q, wdata_n, rdata_q, rd_mask;
  logic [LANES-1:0]  be_q, be_n, lane_n_q;
  logic              cs_n_q, we_n_q, oe_n_q, drv_q, rvalid_q;
  logic              in_cyc, act, wr_ph;

  assign addr_n  = accept_i ? addr_i  : addr_q;
  assign wdata_n = accept_i ? wdata_i : wdata_q;
  assign be_n    = accept_i ? be_i    : be_q;

  assign in_cyc = state_d_i inside {ST_RD_WAIT, ST_WR_SETUP, ST_WR_PULSE};
  assign act    = in_cyc && (|be_n);
  assign wr_ph  = state_d_i inside {ST_WR_SETUP, ST_WR_PULSE};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      drv_q   <= 1'b0;
    end else begin
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      be_q    <= be_n;
      cs_n_q  <= !act;
      we_n_q  <= !(act && state_d_i == ST_WR_PULSE);
      oe_n_q  <= !(act && state_d_i == ST_RD_WAIT);
      drv_q   <= act && wr_ph;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_n_q[l] <= 1'b1;
      else         lane_n_q[l] <= !(act && be_n[l]);
    end
    assign rd_mask[l*8 +: 8] = be_q[l] ? ram_dq_io[l*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= cap_i;
      if (cap_i) rdata_q <= rd_mask;
    end
  end

  assign ram_dq_io    = drv_q ? wdata_q : 'z;
  assign ram_addr_o   = addr_q;
  assign ram_cs_n_o   = cs_n_q;
  assign ram_we_n_o   = we_n_q;
  assign ram_oe_n_o   = oe_n_q;
  assign ram_lane_n_o = lane_n_q;
  assign rdata_o      = rdata_q;
  assign rvalid_o     = rvalid_q;

  // cycles output enable has been high, saturating at the turnaround budget
  logic [TC_W-1:0] oe_hi_cnt;
  logic [WC_W-1:0] we_lo_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_hi_cnt <= TC_W'(TURN_CYC);
      we_lo_cnt <= '0;
    end else begin
      if (!oe_n_q)                        oe_hi_cnt <= '0;
      else if (oe_hi_cnt < TC_W'(TURN_CYC)) oe_hi_cnt <= oe_hi_cnt + 1'b1;
      if (!we_n_q) we_lo_cnt <= we_lo_cnt + 1'b1;
      else         we_lo_cnt <= '0;
    end
  end

  p_idle_pins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_q |-> (&lane_n_q) && oe_n_q && we_n_q && !drv_q);

  p_we_needs_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_q |-> !cs_n_q && !(&lane_n_q));

  p_no_oe_we_overlap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_q |-> we_n_q);

  p_drive_after_turn_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_q |-> oe_n_q && (oe_hi_cnt >= TC_W'(TURN_CYC)));

  p_addr_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_q && !$past(cs_n_q)) |-> ($stable(addr_q) && $stable(wdata_q)));

  p_we_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_q) |-> (we_lo_cnt == WC_W'(PULSE_CYC)));

  p_rvalid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_q |=> !rvalid_q);

  p_sel_needs_lane_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_q |-> (|be_q));

endmodule

// File: rtl/sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 16,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_OE_ACC_NS   = 30,
  parameter int T_WC_NS       = 55,
  parameter int T_WP_NS       = 45,
  parameter int T_SEL_SU_NS   = 50,
  parameter int T_DS_NS       = 25,
  parameter int T_AS_NS       = 0,
  parameter int T_WR_NS       = 0,
  parameter int T_OE_HZ_NS    = 20,
  localparam int LANES        = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_cs_n_o,
  output logic              ram_we_n_o,
  output logic              ram_oe_n_o,
  output logic [LANES-1:0]  ram_lane_n_o,
  inout  wire  [DATA_W-1:0] ram_dq_io
);

  localparam int P         = CLK_PERIOD_NS;
  localparam int RD_CYC    = imax(ns_to_cyc(T_RC_NS, P),
                                  imax(ns_to_cyc(T_AA_NS, P), ns_to_cyc(T_OE_ACC_NS, P)));
  localparam int SETUP_CYC = imax(1, ns_to_cyc(T_AS_NS, P));
  localparam int PULSE_CYC = imax(imax(ns_to_cyc(T_WP_NS, P), ns_to_cyc(T_DS_NS, P)),
                                  imax(ns_to_cyc(T_WC_NS, P) - SETUP_CYC,
                                       ns_to_cyc(T_SEL_SU_NS, P) - SETUP_CYC));
  localparam int WREC_CYC  = imax(1, ns_to_cyc(T_WR_NS, P));
  localparam int TURN_CYC  = imax(1, ns_to_cyc(T_OE_HZ_NS, P));

  seq_state_e state_d;
  logic       accept, cap;

  sram_cyc_fsm #(
    .RD_CYC   (RD_CYC),
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .WREC_CYC (WREC_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .ready_o  (ready_o),
    .accept_o (accept),
    .cap_o    (cap),
    .state_d_o(state_d)
  );

  sram_pin_drv #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LANES    (LANES),
    .PULSE_CYC(PULSE_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_d_i   (state_d),
    .accept_i    (accept),
    .cap_i       (cap),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .be_i        (be_i),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o),
    .ram_addr_o  (ram_addr_o),
    .ram_cs_n_o  (ram_cs_n_o),
    .ram_we_n_o  (ram_we_n_o),
    .ram_oe_n_o  (ram_oe_n_o),
    .ram_lane_n_o(ram_lane_n_o),
    .ram_dq_io   (ram_dq_io)
  );

endmodule

// File: tb/sram_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_tb_top;

  localparam int CLK_NS = 8;
  localparam int AW = 17;
  localparam int DW = 16;

  function automatic int cdiv(int a, int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_E    = mx(cdiv(55, CLK_NS), cdiv(30, CLK_NS));
  localparam int PULSE_E = mx(mx(cdiv(45, CLK_NS), cdiv(25, CLK_NS)), cdiv(50, CLK_NS) - 1);
  localparam int TURN_E  = cdiv(20, CLK_NS);
  localparam int WLAT_E  = 1 + PULSE_E + 1;
  localparam int RLAT_E  = RD_E + TURN_E;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0]    be = '0;
  logic          ready, rvalid, cs_n, we_n, oe_n;
  logic [DW-1:0] rdata;
  logic [AW-1:0] ram_addr;
  logic [1:0]    lane_n;
  wire  [DW-1:0] ram_dq;

  always #(CLK_NS / 2) clk = ~clk;

  sram_cycle_ctrl #(.CLK_PERIOD_NS(CLK_NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .ready_o(ready), .rdata_o(rdata), .rvalid_o(rvalid),
    .ram_addr_o(ram_addr), .ram_cs_n_o(cs_n), .ram_we_n_o(we_n), .ram_oe_n_o(oe_n),
    .ram_lane_n_o(lane_n), .ram_dq_io(ram_dq)
  );

  // behavioural RAM on the shared bus
  logic [DW-1:0] mem [logic [AW-1:0]];
  logic [DW-1:0] rd_q = '0;
  wire           model_en = !cs_n && !oe_n && we_n;
  always @(posedge clk) rd_q <= mem.exists(ram_addr) ? mem[ram_addr] : '0;
  assign ram_dq[7:0]  = (model_en && !lane_n[0]) ? rd_q[7:0]  : 8'hzz;
  assign ram_dq[15:8] = (model_en && !lane_n[1]) ? rd_q[15:8] : 8'hzz;
  always @(negedge clk) begin
    if (rst_n && !cs_n && !we_n) begin
      logic [DW-1:0] cur;
      cur = mem.exists(ram_addr) ? mem[ram_addr] : '0;
      if (!lane_n[0]) cur[7:0]  = ram_dq[7:0];
      if (!lane_n[1]) cur[15:8] = ram_dq[15:8];
      mem[ram_addr] = cur;
    end
  end

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_mem [logic [AW-1:0]];
  logic [DW-1:0] exp_q [$];
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;
  bit            nolane_op = 0, nolane_sel = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(bit w, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] b);
    int lat;
    logic [DW-1:0] old, e;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; be = b;
    cur_addr = a; cur_wdata = d;
    old = exp_mem.exists(a) ? exp_mem[a] : '0;
    if (w) begin
      e = old;
      if (b[0]) e[7:0]  = d[7:0];
      if (b[1]) e[15:8] = d[15:8];
      exp_mem[a] = e;
    end else begin
      e = {b[1] ? old[15:8] : 8'h00, b[0] ? old[7:0] : 8'h00};
      exp_q.push_back(e);
    end
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    chk("R2 ready drops after accept", {31'd0, ready}, 32'd0);
    lat = 0;
    while (!ready) begin
      lat++;
      @(negedge clk);
    end
    chk(w ? "R2 write ready latency" : "R2 read ready latency", lat, w ? WLAT_E : RLAT_E);
  endtask

  // monitor: scoreboard pop, strobe widths, bus rules
  int we_run = 0, oe_run = 0, trn = 0;
  bit prev_rv = 0, prev_oe = 1, after_rd = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rvalid) begin
        chk("R4 rvalid single pulse", {31'd0, prev_rv}, 32'd0);
        if (exp_q.size() == 0) chk("R4 unexpected rvalid", 1, 0);
        else chk("R4 read data", rdata, exp_q.pop_front());
      end
      prev_rv = rvalid;
      if (!we_n) begin
        we_run++;
        chk("R7 write strobe qualified", {cs_n, &lane_n, !oe_n}, 3'b000);
        chk("R5 address/data stable in pulse", {ram_addr, ram_dq}, {cur_addr, cur_wdata});
      end else if (we_run != 0) begin
        chk("R5 write pulse width", we_run, PULSE_E);
        chk("R10 strobes high at write end", {cs_n, lane_n}, 3'b111);
        we_run = 0;
      end
      if (!oe_n) oe_run++;
      else if (oe_run != 0) begin
        chk("R3 output enable width", oe_run, RD_E);
        oe_run = 0;
      end
      if (after_rd) begin
        if (!ready) trn++;
        else begin
          chk("R8 turnaround cycles", trn, TURN_E);
          after_rd = 0;
        end
      end
      if (!prev_oe && oe_n) begin
        after_rd = 1;
        trn = 1;
      end
      prev_oe = oe_n;
      if (nolane_op && !cs_n) nolane_sel = 1;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset strobes", {cs_n, we_n, oe_n, lane_n, ready}, 6'b111111);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle strobes", {cs_n, we_n, oe_n, lane_n, ready}, 6'b111111);

    do_op(1, 17'h00010, 16'hA5C3, 2'b11);   // R5
    do_op(0, 17'h00010, 16'h0000, 2'b11);   // R3 R4
    do_op(1, 17'h00010, 16'h1234, 2'b01);   // R6 low byte only
    do_op(0, 17'h00010, 16'h0000, 2'b11);
    do_op(1, 17'h00010, 16'hFF00, 2'b10);   // R6 high byte only
    do_op(0, 17'h00010, 16'h0000, 2'b01);   // R4 masked upper
    do_op(0, 17'h00010, 16'h0000, 2'b10);   // R4 masked lower

    nolane_op = 1;
    do_op(1, 17'h00010, 16'h0000, 2'b00);   // R9 write without lanes
    do_op(0, 17'h00010, 16'h0000, 2'b00);   // R9 read returns zero
    nolane_op = 0;
    chk("R9 select never low", {31'd0, nolane_sel}, 32'd0);
    do_op(0, 17'h00010, 16'h0000, 2'b11);   // R9 memory unchanged

    do_op(1, 17'h1FFFF, 16'hBEEF, 2'b11);
    do_op(1, 17'h00000, 16'h0001, 2'b11);
    do_op(0, 17'h1FFFF, 16'h0000, 2'b11);
    do_op(0, 17'h00000, 16'h0000, 2'b11);
    do_op(0, 17'h00123, 16'h0000, 2'b11);

    for (int i = 0; i < 4; i++) begin
      do_op(1, 17'(17'h00200 + i), 16'(16'h3C00 + i * 16'h0111), 2'b11);
      do_op(0, 17'(17'h00200 + i), 16'h0000, 2'b11);
    end
    for (int i = 0; i < 4; i++) do_op(0, 17'(17'h00200 + i), 16'h0000, 2'(i));

    repeat (4) @(negedge clk);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    chk("R1 idle after traffic", {cs_n, we_n, oe_n, lane_n, ready}, 6'b111111);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule